// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire management bus with an open-drain data line. It holds a small bank of 8-bit configuration registers that come out of reset with fixed defaults. A bus master can reach the bank in two ways. It can address one register directly, or it can stream through the whole bank from register zero. The register contents are presented in parallel on `cfg_bytes`, so the surrounding logic can use them as live configuration.

The bus clock and data are sampled by a fast system clock through synchronisers. START, STOP, bit edges and the acknowledge slots are all derived from those samples. The command code that follows the address selects the access mode. When its top bit is set, the low seven bits give a register offset for a single-byte access. When its top bit is clear, the access is a counted block transfer that starts at register 0. In a block write the first byte after the command is a byte count. A block read answers with a byte count before the register data.

Top module: `twi_regbank_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 1101110 (DCh to write, DDh to read). Any other address is not acknowledged, and the slave then leaves SDA alone until the next START.
- R2: Command bit 7 = 1 selects single-byte access at the offset in bits 6:0. Command bit 7 = 0 selects block access beginning at register 0.
- R3: In a block write, the byte after the command is a byte count and is not stored. The following data bytes land in registers 0, 1, 2 and so on. A STOP after any complete byte leaves the remaining registers unchanged. Each data byte is acknowledged.
- R4: A block read is a write phase carrying the command, then a repeated START with the read address. The slave answers with the count 06h, then with registers 0 upward for as long as the master acknowledges.
- R5: A byte read returns the register at the commanded offset. All data leaves the slave most significant bit first.
- R6: After reset the bank holds byte0=07h, byte1=FFh, byte2=00h, byte3=00h, byte4=08h, byte5=00h. `cfg_bytes` carries byte i on bits 8i+7:8i.
- R7: Byte 4 is read-only. A write to byte 4, or to any offset of 6 or more, is acknowledged but changes nothing. A read of an offset of 6 or more returns 00h.
- R8: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next START or STOP.
- R9: SDA falling while SCL is high is a START from any state, and it restarts address reception. SDA rising while SCL is high is a STOP and returns the slave to idle. Bits clocked with no START before them are ignored.
- R10: The slave never begins pulling SDA low while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| cfg_bytes | output | 48 | Register bank contents, byte i on bits 8i+7:8i |

## Verification
On the falling SCL edge that closes the eighth bit of a data byte, two things happen in the same system-clock cycle. The register write commits, and the slave starts pulling SDA low for the acknowledge. The bench provokes this with every data byte of the byte writes and the block writes. For each one it judges both results: it samples the acknowledge during the following SCL high phase, and it checks the parallel register output after STOP. Block writes that cross the read-only register are used to show that the acknowledge is still given while the register does not change.

// File: rtl/twi_pkg.sv
package twi_pkg;
   localparam int unsigned TWI_OFS_W = 7;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RX,
      S_RACK,
      S_TX,
      S_TACK
   } twi_st_e;

   typedef enum logic [1:0] {
      ROLE_ADDR,
      ROLE_CMD,
      ROLE_CNT,
      ROLE_DATA
   } twi_role_e;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   if (STAGES < 2) begin : g_chk
      $error("twi_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_p;
   logic              sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_p  <= scl_ff[STAGES-1];
         sda_p  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;

   // R9: START and STOP are never seen together
   p_start_stop_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_evt && stop_evt));
endmodule

// File: rtl/twi_regfile.sv
module twi_regfile
   import twi_pkg::*;
#(
   parameter int unsigned          NREG    = 6,
   parameter logic [NREG*8-1:0]    RST_VAL = {8'h00, 8'h08, 8'h00, 8'h00, 8'hFF, 8'h07},
   parameter logic [NREG-1:0]      RO_MASK = 6'b01_0000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [TWI_OFS_W-1:0] waddr,
   input  logic [7:0]           wdata,
   input  logic [TWI_OFS_W-1:0] raddr,
   output logic [7:0]           rdata,
   output logic [NREG*8-1:0]    q_flat
);
   localparam logic [TWI_OFS_W-1:0] NREG_A = TWI_OFS_W'(NREG);

   if (NREG < 1 || NREG > 127) begin : g_chk
      $error("twi_regfile: NREG out of range");
   end

   logic [7:0] q [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (RO_MASK[g]) begin : g_ro
         assign q[g] = RST_VAL[8*g +: 8];
      end else begin : g_rw
         logic [7:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               r <= RST_VAL[8*g +: 8];
            else if (we && waddr == TWI_OFS_W'(g))
               r <= wdata;
         end
         assign q[g] = r;
      end
      assign q_flat[8*g +: 8] = q[g];
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NREG; i++)
         if (raddr == TWI_OFS_W'(i)) rdata = q[i];
   end

   // R7: writes beyond the bank leave every register as it was
   p_oob_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr >= NREG_A) |=> $stable(q_flat));
endmodule

// File: rtl/twi_protocol.sv
module twi_protocol
   import twi_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR = 7'h6E,
   parameter int unsigned NREG     = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_s,
   input  logic                 sda_s,
   input  logic                 scl_rise,
   input  logic                 scl_fall,
   input  logic                 start_evt,
   input  logic                 stop_evt,
   input  logic [7:0]           rdata,
   output logic [TWI_OFS_W-1:0] ptr,
   output logic                 we,
   output logic [TWI_OFS_W-1:0] waddr,
   output logic [7:0]           wdata,
   output logic                 sda_oe
);
   localparam logic [7:0] NREG8 = 8'(NREG);

   twi_st_e              st;
   twi_role_e            role;
   logic [3:0]           bitcnt;
   logic [7:0]           shreg;
   logic [7:0]           txb;
   logic                 blk;
   logic [TWI_OFS_W-1:0] ofs;
   logic                 rw;
   logic                 cnt_pend;
   logic                 mack;

   logic [7:0]           nxt_tx;
   logic                 addr_hit;
   logic                 ptr_max;

   assign nxt_tx   = cnt_pend ? NREG8 : rdata;
   assign addr_hit = (shreg[7:1] == DEV_ADDR);
   assign ptr_max  = (ptr == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         role     <= ROLE_ADDR;
         bitcnt   <= '0;
         shreg    <= '0;
         txb      <= '0;
         blk      <= 1'b1;
         ofs      <= '0;
         rw       <= 1'b0;
         cnt_pend <= 1'b0;
         mack     <= 1'b0;
         ptr      <= '0;
         we       <= 1'b0;
         waddr    <= '0;
         wdata    <= '0;
         sda_oe   <= 1'b0;
      end else begin
         we <= 1'b0;
         if (stop_evt) begin
            st     <= S_IDLE;
            sda_oe <= 1'b0;
         end else if (start_evt) begin
            st     <= S_RX;
            role   <= ROLE_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else begin
            unique case (st)
               S_IDLE: ;
               S_RX: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[6:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     bitcnt <= '0;
                     unique case (role)
                        ROLE_ADDR: begin
                           if (addr_hit) begin
                              rw     <= shreg[0];
                              sda_oe <= 1'b1;
                              st     <= S_RACK;
                              if (shreg[0]) begin
                                 ptr      <= blk ? '0 : ofs;
                                 cnt_pend <= blk;
                              end
                           end else begin
                              st <= S_IDLE;
                           end
                        end
                        ROLE_CMD: begin
                           blk    <= ~shreg[7];
                           ofs    <= shreg[6:0];
                           ptr    <= shreg[7] ? shreg[6:0] : '0;
                           sda_oe <= 1'b1;
                           st     <= S_RACK;
                        end
                        ROLE_CNT: begin
                           sda_oe <= 1'b1;
                           st     <= S_RACK;
                        end
                        ROLE_DATA: begin
                           we     <= 1'b1;
                           waddr  <= ptr;
                           wdata  <= shreg;
                           if (!ptr_max) ptr <= ptr + 1'b1;
                           sda_oe <= 1'b1;
                           st     <= S_RACK;
                        end
                     endcase
                  end
               end
               S_RACK: begin
                  if (scl_fall) begin
                     if (role == ROLE_ADDR && rw) begin
                        txb    <= nxt_tx;
                        sda_oe <= ~nxt_tx[7];
                        if (cnt_pend) cnt_pend <= 1'b0;
                        else if (!ptr_max) ptr <= ptr + 1'b1;
                        st     <= S_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= S_RX;
                        unique case (role)
                           ROLE_ADDR: role <= ROLE_CMD;
                           ROLE_CMD:  role <= blk ? ROLE_CNT : ROLE_DATA;
                           default:   role <= ROLE_DATA;
                        endcase
                     end
                  end
               end
               S_TX: begin
                  if (scl_fall) begin
                     if (bitcnt == 4'd7) begin
                        bitcnt <= '0;
                        sda_oe <= 1'b0;
                        st     <= S_TACK;
                     end else begin
                        txb    <= {txb[6:0], 1'b0};
                        sda_oe <= ~txb[6];
                        bitcnt <= bitcnt + 4'd1;
                     end
                  end
               end
               S_TACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack) begin
                        txb    <= nxt_tx;
                        sda_oe <= ~nxt_tx[7];
                        if (cnt_pend) cnt_pend <= 1'b0;
                        else if (!ptr_max) ptr <= ptr + 1'b1;
                        st     <= S_TX;
                     end else begin
                        st <= S_IDLE;
                     end
                  end
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end

   // R1: an address that does not match is never acknowledged
   p_nack_foreign_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RX && role == ROLE_ADDR && scl_fall && bitcnt == 4'd8 && !addr_hit
       && !start_evt && !stop_evt) |=> (!sda_oe && st == S_IDLE));

   // R4: the first byte of a block read is the register count
   p_count_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RACK && role == ROLE_ADDR && rw && blk && scl_fall
       && !start_evt && !stop_evt) |=> (txb == NREG8));

   // R8: a master NACK releases the line and parks the slave
   p_nack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_TACK && scl_fall && !mack && !start_evt && !stop_evt)
      |=> (st == S_IDLE && !sda_oe));

   // R9: STOP always returns to idle with the line released
   p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> (st == S_IDLE && !sda_oe));

   // R10: no new pull-down while the clock is high
   p_no_drive_scl_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s)) |-> !$rose(sda_oe));

   // R3: a block write commits to the address just before the advanced pointer
   p_write_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (ptr == waddr + 1'b1 || ptr == '1));
endmodule

// File: rtl/twi_regbank_slave.sv
module twi_regbank_slave
   import twi_pkg::*;
#(
   parameter logic [6:0]        DEV_ADDR    = 7'h6E,
   parameter int unsigned       NREG        = 6,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [NREG*8-1:0] RST_VAL     = {8'h00, 8'h08, 8'h00, 8'h00, 8'hFF, 8'h07},
   parameter logic [NREG-1:0]   RO_MASK     = 6'b01_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [NREG*8-1:0] cfg_bytes
);
   logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
   logic                 we;
   logic [TWI_OFS_W-1:0] ptr;
   logic [TWI_OFS_W-1:0] waddr;
   logic [7:0]           wdata;
   logic [7:0]           rdata;

   twi_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_evt(start_evt),
      .stop_evt (stop_evt)
   );

   twi_protocol #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_proto (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_evt(start_evt),
      .stop_evt (stop_evt),
      .rdata    (rdata),
      .ptr      (ptr),
      .we       (we),
      .waddr    (waddr),
      .wdata    (wdata),
      .sda_oe   (sda_oe)
   );

   twi_regfile #(.NREG(NREG), .RST_VAL(RST_VAL), .RO_MASK(RO_MASK)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (ptr),
      .rdata (rdata),
      .q_flat(cfg_bytes)
   );
endmodule

// File: tb/sim_twi_regbank_slave.sv
module sim_twi_regbank_slave;
   localparam int Q = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        sda_m = 1'b1;
   logic        sda_oe;
   logic [47:0] cfg_bytes;
   wire         sda_line = sda_m & ~sda_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   int r10_bad = 0;
   logic prev_scl = 1'b1;
   logic prev_oe  = 1'b0;

   always #5 clk = ~clk;

   twi_regbank_slave u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl),
      .sda_i    (sda_line),
      .sda_oe   (sda_oe),
      .cfg_bytes(cfg_bytes)
   );

   always @(negedge clk) begin
      if (rst_n && scl && prev_scl && sda_oe && !prev_oe) r10_bad++;
      prev_scl <= scl;
      prev_oe  <= sda_oe;
   end

   task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic hold();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hold();
      scl = 1'b1;   hold();
      sda_m = 1'b0; hold();
      scl = 1'b0;   hold();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hold();
      scl = 1'b1;   hold();
      sda_m = 1'b1; hold();
   endtask

   task automatic bus_bit(input logic b, output logic s);
      sda_m = b; hold();
      scl = 1'b1; hold();
      s = sda_line; hold();
      scl = 1'b0; hold();
   endtask

   task automatic put_byte(input logic [7:0] d, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bus_bit(d[i], s);
      bus_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic get_byte(input logic ack_m, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bus_bit(1'b1, s);
         d[i] = s;
      end
      bus_bit(~ack_m, s);
   endtask

   // {rd, addr, cmd, wdata, expected read, expected address ack}
   localparam logic [33:0] VEC [0:10] = '{
      {1'b1, 8'hDC, 8'h80, 8'h00, 8'h07, 1'b1},
      {1'b1, 8'hDC, 8'h84, 8'h00, 8'h08, 1'b1},
      {1'b0, 8'hDC, 8'h81, 8'h5A, 8'h00, 1'b1},
      {1'b1, 8'hDC, 8'h81, 8'h00, 8'h5A, 1'b1},
      {1'b0, 8'hDC, 8'h84, 8'hFF, 8'h00, 1'b1},
      {1'b1, 8'hDC, 8'h84, 8'h00, 8'h08, 1'b1},
      {1'b0, 8'hDC, 8'h87, 8'h33, 8'h00, 1'b1},
      {1'b1, 8'hDC, 8'h87, 8'h00, 8'h00, 1'b1},
      {1'b0, 8'hA0, 8'h81, 8'h99, 8'h00, 1'b0},
      {1'b0, 8'hDC, 8'h83, 8'hC3, 8'h00, 1'b1},
      {1'b1, 8'hDC, 8'h83, 8'h00, 8'hC3, 1'b1}
   };

   initial begin
      logic       ack;
      logic [7:0] d;
      logic       s;
      logic [7:0] blk_exp [7];

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      hold();

      // R6: defaults after reset
      chk(cfg_bytes == 48'h00_08_00_00_FF_07, "R6 reset defaults", cfg_bytes, 48'h00_08_00_00_FF_07);
      chk(sda_oe == 1'b0, "R6 line released after reset", 48'(sda_oe), 48'h0);

      for (int v = 0; v < 11; v++) begin
         logic        rd;
         logic [7:0]  ad, cm, wd, ex;
         logic        ea;
         {rd, ad, cm, wd, ex, ea} = VEC[v];
         bus_start();
         put_byte(ad, ack);
         chk(ack == ea, "R1 address acknowledge", 48'(ack), 48'(ea));
         if (ack) begin
            put_byte(cm, ack);
            chk(ack, "R2 command acknowledge", 48'(ack), 48'h1);
            if (rd) begin
               bus_start();
               put_byte({ad[7:1], 1'b1}, ack);
               chk(ack, "R9 repeated start read address", 48'(ack), 48'h1);
               get_byte(1'b0, d);
               chk(d == ex, "R5 R7 byte read", 48'(d), 48'(ex));
            end else begin
               put_byte(wd, ack);
               chk(ack, "R7 data acknowledge", 48'(ack), 48'h1);
            end
         end
         bus_stop();
      end
      chk(cfg_bytes == 48'h00_08_C3_00_5A_07, "R7 bank after byte writes", cfg_bytes, 48'h00_08_C3_00_5A_07);

      // R3: block write with count 3 and early STOP
      bus_start();
      put_byte(8'hDC, ack);
      put_byte(8'h00, ack);
      put_byte(8'h03, ack);
      chk(ack, "R3 count acknowledge", 48'(ack), 48'h1);
      put_byte(8'h11, ack);
      put_byte(8'h22, ack);
      put_byte(8'h33, ack);
      chk(ack, "R3 block data acknowledge", 48'(ack), 48'h1);
      bus_stop();
      chk(cfg_bytes == 48'h00_08_C3_33_22_11, "R3 block write", cfg_bytes, 48'h00_08_C3_33_22_11);

      // R4: block read returns count then data
      blk_exp = '{8'h06, 8'h11, 8'h22, 8'h33, 8'hC3, 8'h08, 8'h00};
      bus_start();
      put_byte(8'hDC, ack);
      put_byte(8'h00, ack);
      bus_start();
      put_byte(8'hDD, ack);
      for (int i = 0; i < 7; i++) begin
         get_byte(i != 6, d);
         chk(d == blk_exp[i], "R4 block read byte", 48'(d), 48'(blk_exp[i]));
      end
      bus_stop();

      // R7: full block write crossing the read-only register
      bus_start();
      put_byte(8'hDC, ack);
      put_byte(8'h00, ack);
      put_byte(8'h06, ack);
      for (int i = 0; i < 6; i++) begin
         put_byte(8'hA0 + 8'(i), ack);
         chk(ack, "R7 block data acknowledge", 48'(ack), 48'h1);
      end
      bus_stop();
      chk(cfg_bytes == 48'hA5_08_A3_A2_A1_A0, "R7 read-only kept in block write", cfg_bytes, 48'hA5_08_A3_A2_A1_A0);

      // R2: byte access at offset 2
      bus_start();
      put_byte(8'hDC, ack);
      put_byte(8'h82, ack);
      bus_start();
      put_byte(8'hDD, ack);
      get_byte(1'b0, d);
      chk(d == 8'hA2, "R2 byte read offset 2", 48'(d), 48'hA2);
      bus_stop();

      // R8: master NACKs after the count, then the slave stays off the line
      bus_start();
      put_byte(8'hDC, ack);
      put_byte(8'h00, ack);
      bus_start();
      put_byte(8'hDD, ack);
      get_byte(1'b0, d);
      chk(d == 8'h06, "R8 count before nack", 48'(d), 48'h06);
      get_byte(1'b1, d);
      get_byte(1'b1, d);
      chk(d == 8'hFF, "R8 line released after nack", 48'(d), 48'hFF);
      bus_stop();

      // R9: bits without START are ignored
      put_byte(8'hDC, ack);
      chk(!ack, "R9 no ack without start", 48'(ack), 48'h0);
      bus_stop();

      // R10: no pull-down began while SCL was high
      chk(r10_bad == 0, "R10 drive only with clock low", 48'(r10_bad), 48'h0);

      // R6: a second reset restores defaults
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      hold();
      chk(cfg_bytes == 48'h00_08_00_00_FF_07, "R6 defaults after second reset", cfg_bytes, 48'h00_08_00_00_FF_07);

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule